// File: doc/BRIEF.md
# Refresh and realtime clock ticker

This block turns one periodic timer into the housekeeping heartbeat of a memory system. The timer period is set at build time as a count of processor cycles. From it the block derives a 16-bit period word: state `0101`, a data field holding the period in units of 64 cycles, and slot `1111`. The timer counts in those units. On each expiry a small sequencer does three things in turn. It emits one DRAM refresh request carrying the current refresh row state. It then advances that state by a fixed step without touching its low bits. It also bumps a realtime clock kept as a low half and a high half. With the strobe option built in, every 32nd expiry also produces a one-cycle I/O strobe.

The timer is re-armed by adding the period to its remaining count, not by reloading it, so ticks land on exact multiples of the period. An initialisation pulse restarts the timing and the strobe count and clears the low bits of the refresh state. It leaves the clock and the upper refresh bits alone, so the refresh sequence carries on without a gap.

The sequencer has three states. `ST_COUNT` waits for expiry; on expiry it takes the *expire* transition to `ST_REFRESH`. `ST_REFRESH` drives the request and always takes the *issue* transition to `ST_CLOCK`. `ST_CLOCK` commits the clock, row and strobe updates and takes the *commit* transition back to `ST_COUNT`. The *init* transition from any state goes to `ST_COUNT`.

Top module: `rt_refresh_clock`

## Requirements
- R1: Let W = 0o50017 + ((PERIOD_CYC >> 6) << 4) and U = W[11:4]. The tick period is P = U*64 cycles. The first `refresh_req` is high exactly P cycles after reset release or after the clock edge that samples `init_i`. Later requests follow every P cycles with no drift.
- R2: `refresh_req` is high for exactly one cycle per expiry. While it is high, `refresh_row` shows the refresh state used by that reference.
- R3: Two cycles after a request, the refresh state has grown by STEP (default 16) modulo 2^REFR_W. Its low log2(STEP) bits stay unchanged.
- R4: `clk_lo` grows by one per tick. The new value is visible two cycles after the request cycle.
- R5: When `clk_lo` wraps from all ones to zero, `clk_hi` grows by one in the same cycle.
- R6: With STROBE_EN=1, `io_strobe` is a one-cycle pulse on every 32nd tick, in the same cycle as that tick's clock update (request cycle + 2). At no other time is it high.
- R7: `init_i` clears the low log2(STEP) bits of the refresh state and keeps the upper bits. It restarts the period timing and the strobe count. It leaves `clk_lo` and `clk_hi` unchanged.
- R8: After reset, `refresh_req`, `io_strobe`, `clk_lo` and `clk_hi` are zero, and `refresh_row` equals REFR_RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_i | input | 1 | Restart timing and strobe count; clear low refresh bits |
| refresh_req | output | 1 | One-cycle refresh reference request |
| refresh_row | output | REFR_W | Refresh row state (valid with `refresh_req`) |
| clk_lo | output | HALF_W | Realtime clock low half |
| clk_hi | output | HALF_W | Realtime clock high half |
| io_strobe | output | 1 | One-cycle strobe every 32nd tick |

## Verification
A wrong period count or a re-arm that drifts shows up as a refresh request that is early or late against the P-cycle grid. This becomes visible at the first expiry after reset or init. A bad row step or clobbered low bits show up on `refresh_row` with the next request, one period later. A lost carry shows up only when `clk_lo` wraps, so the bench narrows the clock halves to reach that point within a few dozen ticks. A strobe divider that is off by one, or one that is not restarted by init, is caught at the 32nd tick after reset or init.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic [1:0] {
        ST_COUNT   = 2'd0,
        ST_REFRESH = 2'd1,
        ST_CLOCK   = 2'd2
    } rt_state_e;

    // Period word: state nibble 0101, data field [11:4] = cycles >> shift, slot 1111.
    function automatic int period_word(input int cyc, input int shift);
        return 'o50017 + ((cyc >> shift) << 4);
    endfunction

    function automatic int period_units(input int cyc, input int shift);
        return (period_word(cyc, shift) >> 4) & 'hFF;
    endfunction

endpackage

// File: rtl/rt_tick_gen.sv
module rt_tick_gen #(
    parameter int PERIOD_CYC = 2560,
    parameter int UNIT_SHIFT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    output logic expire_o
);
    localparam int UNITS = rt_pkg::period_units(PERIOD_CYC, UNIT_SHIFT);
    localparam int CNT_W = 8;

    logic [UNIT_SHIFT-1:0] pre_q;
    logic [CNT_W-1:0]      rem_q;
    logic                  unit_tick;
    logic [CNT_W-1:0]      rem_dec;

    assign unit_tick = &pre_q;
    assign rem_dec   = rem_q - CNT_W'(1);
    assign expire_o  = unit_tick && (rem_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            pre_q <= '0;
            rem_q <= CNT_W'(UNITS);
        end else begin
            pre_q <= pre_q + UNIT_SHIFT'(1);
            if (unit_tick) begin
                // re-arm by adding the period to what is left
                if (rem_dec == '0) begin
                    rem_q <= rem_dec + CNT_W'(UNITS);
                end else begin
                    rem_q <= rem_dec;
                end
            end
        end
    end
endmodule

// File: rtl/rt_seq.sv
module rt_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic expire_i,
    output logic req_o,
    output logic upd_o
);
    import rt_pkg::*;

    rt_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNT:   if (expire_i) state_d = ST_REFRESH;
            ST_REFRESH: state_d = ST_CLOCK;
            ST_CLOCK:   state_d = ST_COUNT;
            default:    state_d = ST_COUNT;
        endcase
        if (init_i) state_d = ST_COUNT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        req_o = 1'b0;
        upd_o = 1'b0;
        unique case (state_q)
            ST_COUNT:   ;
            ST_REFRESH: req_o = 1'b1;
            ST_CLOCK:   upd_o = !init_i;
            default:    ;
        endcase
    end
endmodule

// File: rtl/rt_clock.sv
module rt_clock #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o
);
    logic [HALF_W:0] lo_sum;

    assign lo_sum = {1'b0, lo_o} + (HALF_W+1)'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o <= '0;
            hi_o <= '0;
        end else if (upd_i) begin
            lo_o <= lo_sum[HALF_W-1:0];
            hi_o <= hi_o + HALF_W'(lo_sum[HALF_W]);
        end
    end
endmodule

// File: rtl/rt_strobe_div.sv
module rt_strobe_div #(
    parameter bit STROBE_EN  = 1'b1,
    parameter int STROBE_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init_i,
    input  logic upd_i,
    output logic strobe_o
);
    localparam int DIV_W = (STROBE_DIV > 1) ? $clog2(STROBE_DIV) : 1;

    generate
        if (STROBE_EN) begin : g_div
            logic [DIV_W-1:0] div_q;
            logic             last;
            assign last = (div_q == DIV_W'(STROBE_DIV - 1));
            always_ff @(posedge clk) begin
                if (!rst_n || init_i) begin
                    div_q    <= '0;
                    strobe_o <= 1'b0;
                end else begin
                    strobe_o <= upd_i && last;
                    if (upd_i) div_q <= last ? '0 : div_q + DIV_W'(1);
                end
            end
        end else begin : g_off
            assign strobe_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rt_refresh_clock.sv
module rt_refresh_clock #(
    parameter int                PERIOD_CYC = 2560,
    parameter int                UNIT_SHIFT = 6,
    parameter int                HALF_W     = 16,
    parameter int                REFR_W     = 16,
    parameter int                STEP       = 16,
    parameter logic [REFR_W-1:0] REFR_RESET = '0,
    parameter bit                STROBE_EN  = 1'b1,
    parameter int                STROBE_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    output logic              refresh_req,
    output logic [REFR_W-1:0] refresh_row,
    output logic [HALF_W-1:0] clk_lo,
    output logic [HALF_W-1:0] clk_hi,
    output logic              io_strobe
);
    localparam int LOW_W    = $clog2(STEP);
    localparam int TICK_CYC = rt_pkg::period_units(PERIOD_CYC, UNIT_SHIFT) << UNIT_SHIFT;
    localparam logic [REFR_W-1:0] LOW_MASK = REFR_W'((1 << LOW_W) - 1);

    logic expire;
    logic upd;
    logic [REFR_W-1:0] refr_q;

    rt_tick_gen #(.PERIOD_CYC(PERIOD_CYC), .UNIT_SHIFT(UNIT_SHIFT)) u_tick (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .expire_o(expire)
    );

    rt_seq u_seq (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .expire_i(expire),
        .req_o(refresh_req), .upd_o(upd)
    );

    rt_clock #(.HALF_W(HALF_W)) u_clock (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .lo_o(clk_lo), .hi_o(clk_hi)
    );

    rt_strobe_div #(.STROBE_EN(STROBE_EN), .STROBE_DIV(STROBE_DIV)) u_strobe (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .upd_i(upd), .strobe_o(io_strobe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      refr_q <= REFR_RESET;
        else if (init_i) refr_q <= refr_q & ~LOW_MASK;
        else if (upd)    refr_q <= refr_q + REFR_W'(STEP);
    end

    assign refresh_row = refr_q;
endmodule

// File: rtl/rt_refresh_clock_chk.sv
module rt_refresh_clock_chk #(
    parameter int REFR_W   = 16,
    parameter int HALF_W   = 16,
    parameter int STEP     = 16,
    parameter int TICK_CYC = 2560
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_i,
    input logic              refresh_req,
    input logic [REFR_W-1:0] refresh_row,
    input logic [HALF_W-1:0] clk_lo,
    input logic [HALF_W-1:0] clk_hi,
    input logic              io_strobe
);
    localparam int LOW_W = $clog2(STEP);

    int unsigned gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) gap_q <= 0;
        else if (refresh_req) gap_q <= 1;
        else                  gap_q <= gap_q + 1;
    end

    a_r1_on_grid: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |-> gap_q == TICK_CYC);
    a_r1_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= TICK_CYC);
    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_req |=> !refresh_req);
    a_r3_row_step: assert property (@(posedge clk) disable iff (!rst_n || init_i)
        refresh_req |-> ##2 (refresh_row == REFR_W'($past(refresh_row, 2) + REFR_W'(STEP))));
    a_r3_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> refresh_row[LOW_W-1:0] == $past(refresh_row[LOW_W-1:0]));
    a_r4_lo_inc: assert property (@(posedge clk) disable iff (!rst_n || init_i)
        refresh_req |-> ##2 (clk_lo == HALF_W'($past(clk_lo, 2) + HALF_W'(1))));
    a_r5_carry: assert property (@(posedge clk) disable iff (!rst_n || init_i)
        (refresh_req && (&clk_lo)) |-> ##2 (clk_hi == HALF_W'($past(clk_hi, 2) + HALF_W'(1))));
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        io_strobe |=> !io_strobe);
    a_r6_strobe_with_update: assert property (@(posedge clk) disable iff (!rst_n)
        io_strobe |-> clk_lo != $past(clk_lo));
    a_r7_clock_kept: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (clk_lo == $past(clk_lo)) && (clk_hi == $past(clk_hi)));
endmodule

bind rt_refresh_clock rt_refresh_clock_chk #(
    .REFR_W(REFR_W), .HALF_W(HALF_W), .STEP(STEP), .TICK_CYC(TICK_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .refresh_req(refresh_req),
    .refresh_row(refresh_row), .clk_lo(clk_lo), .clk_hi(clk_hi), .io_strobe(io_strobe)
);

// File: tb/test_rt_refresh_clock.sv
`timescale 1ns/1ps
module test_rt_refresh_clock;
    localparam int PCYC = 130;
    localparam int P    = ((PCYC >> 6) & 'hFF) * 64;   // R1: data field times 64 -> 128
    localparam int NT   = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_i = 1'b0;
    logic refresh_req, io_strobe;
    logic [7:0] refresh_row;
    logic [3:0] clk_lo, clk_hi;

    always #2 clk = ~clk;

    rt_refresh_clock #(
        .PERIOD_CYC(PCYC), .UNIT_SHIFT(6), .HALF_W(4), .REFR_W(8), .STEP(16),
        .REFR_RESET(8'h0B), .STROBE_EN(1'b1), .STROBE_DIV(32)
    ) i_rt_refresh_clock (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .refresh_req(refresh_req),
        .refresh_row(refresh_row), .clk_lo(clk_lo), .clk_hi(clk_hi), .io_strobe(io_strobe)
    );

    typedef struct {
        int   cyc;
        int   row;
        int   lo;
        int   hi;
        bit   strb;
    } exp_t;

    exp_t q[$];
    exp_t pend_it;
    bit   pend = 0;
    int   pend_cyc;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string r, input int act, input int ex);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", r, act, ex, cyc);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // driver side: push expected ticks
    task automatic push_ticks(input int base, input int row0, input int done_before);
        for (int m = 1; m <= NT; m++) begin
            exp_t e;
            int t;
            t      = done_before + m;
            e.cyc  = base + m * P;
            e.row  = (row0 + 16 * (m - 1)) & 'hFF;
            e.lo   = t % 16;
            e.hi   = (t / 16) % 16;
            e.strb = (m % 32) == 0;
            q.push_back(e);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (io_strobe && !(pend && cyc == pend_cyc && pend_it.strb))
                chk(1'b0, "R6 stray strobe", 1, 0);
            if (pend && cyc == pend_cyc) begin
                chk(clk_lo == pend_it.lo[3:0], "R4 clk_lo", clk_lo, pend_it.lo);
                chk(clk_hi == pend_it.hi[3:0], "R5 clk_hi", clk_hi, pend_it.hi);
                chk(io_strobe == pend_it.strb, "R6 strobe", io_strobe, pend_it.strb);
                pend = 0;
            end
            if (refresh_req) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R2 unexpected refresh", 1, 0);
                end else begin
                    pend_it = q.pop_front();
                    chk(cyc == pend_it.cyc, "R1 refresh timing", cyc, pend_it.cyc);
                    chk(refresh_row == pend_it.row[7:0], "R3 refresh row", refresh_row, pend_it.row);
                    pend     = 1;
                    pend_cyc = cyc + 2;
                end
            end
            if (pend && cyc == pend_cyc - 1)
                chk(!refresh_req, "R2 single pulse", refresh_req, 0);
        end
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        chk(!refresh_req, "R8 refresh_req", refresh_req, 0);
        chk(!io_strobe, "R8 io_strobe", io_strobe, 0);
        chk(clk_lo == 0, "R8 clk_lo", clk_lo, 0);
        chk(clk_hi == 0, "R8 clk_hi", clk_hi, 0);
        chk(refresh_row == 8'h0B, "R8 refresh_row", refresh_row, 'h0B);
        push_ticks(0, 'h0B, 0);
        wait (q.size() == 0 && !pend);
        repeat (8) @(negedge clk);
        // R7: init mid-period
        init_i = 1'b1;
        @(negedge clk);
        init_i = 1'b0;
        base = cyc;
        chk(refresh_row == 8'h80, "R7 low bits cleared", refresh_row, 'h80);
        chk(clk_lo == 4'd8, "R7 clk_lo kept", clk_lo, 8);
        chk(clk_hi == 4'd2, "R7 clk_hi kept", clk_hi, 2);
        push_ticks(base, 'h80, NT);
        wait (q.size() == 0 && !pend);
        repeat (4) @(negedge clk);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        summary();
    end
endmodule